// File: doc/BRIEF.md
# Drift-Compensated One-Second Time Base

This block produces a one-second tick for a real-time clock from a crystal-derived count enable. A 16-bit counter advances on each enabled clock and wraps when it reaches the active match value. Each wrap ends one second. Software programs the base match value M. The length of one second is therefore M+1 enabled counts.

To trim a crystal that runs slightly fast or slow, compensation can stretch some seconds by one count. The seconds are grouped into compensation cycles of 5, 15, 30 or 60 seconds. Within a cycle, the first Q seconds use M+1 as the match value and the remaining seconds use M. The average second length is then adjusted by Q/L of a count, where L is the cycle length.

The block also produces a quarter-second tick. It keeps two sticky status flags with interrupt requests. One flag records quarter-second ticks and the other marks the last second of a compensation cycle. The settings M, cycle select, Q and enable are taken only at the start of a cycle. A cycle therefore never mixes two settings.

Top module: `rtc_drift_comp`

## Requirements
- R1: After reset, `count` is 0. The counter first moves on the second clock after reset is released. From then on it rises by exactly one on every clock with `cnt_en` high that is not a wrap, and it holds on every clock with `cnt_en` low.
- R2: Let X be the active match value. When `count` equals X and `cnt_en` is high, the next edge sets `count` to 0 and raises `sec_tick` for exactly that one cycle. Each second therefore lasts X+1 enabled counts.
- R3: The cycle select sets the compensation cycle length in seconds: 0 gives 5, 1 gives 15, 2 gives 30 and 3 gives 60. A second index runs from 0 to L-1 and then restarts at 0 with a new cycle.
- R4: With compensation on, seconds with index below Q use X = M+1. Seconds with index Q or above use X = M.
- R5: With compensation off, or with Q = 0, every second uses X = M.
- R6: With compensation on and Q greater than or equal to L, every second of the cycle uses X = M+1.
- R7: M, the cycle select, Q and the compensation enable are sampled once on the first clock after reset, and again only when a cycle ends. Changes made in the middle of a cycle take effect from the next cycle.
- R8: `qtr_tick` pulses for one cycle each time `count` takes one of these values: 0 (on a wrap), floor(X/4), floor(X/2) or floor(3X/4). M is assumed to be at least 3.
- R9: With compensation on, `comp_flag` sets on the clock after the `sec_tick` that begins the second with index L-1. The flag then stays set until it is cleared.
- R10: `tick_flag` sets on the clock after each `qtr_tick` pulse.
- R11: A high `tick_clr` or `comp_clr` clears the matching flag on the next edge. If the flag sets in the same cycle, the set wins.
- R12: `tick_irq` is high exactly when `tick_flag` and `tick_ie` are both high. `comp_irq` is high exactly when `comp_flag` and `comp_ie` are both high.
- R13: Reset clears both flags, both ticks, the counter and the second index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Crystal-derived count enable |
| mod_val | input | 16 | Base match value M |
| cyc_sel | input | 2 | Compensation cycle length select |
| stretch_q | input | 6 | Number of stretched seconds per cycle (Q) |
| comp_en | input | 1 | Compensation enable |
| tick_ie | input | 1 | Quarter-tick interrupt enable |
| comp_ie | input | 1 | Cycle-flag interrupt enable |
| tick_clr | input | 1 | Clear strobe for the quarter-tick flag |
| comp_clr | input | 1 | Clear strobe for the cycle flag |
| count | output | 16 | Current counter value |
| sec_tick | output | 1 | One-cycle pulse when a second ends |
| qtr_tick | output | 1 | One-cycle quarter-second pulse |
| tick_flag | output | 1 | Sticky quarter-tick flag |
| comp_flag | output | 1 | Sticky last-second-of-cycle flag |
| tick_irq | output | 1 | Quarter-tick interrupt request |
| comp_irq | output | 1 | Cycle interrupt request |

## Verification
The bench builds the block with its default widths: a 16-bit counter and a 6-bit Q. It programs small M values, between 4 and 10, so that each second lasts only a handful of clocks. With seconds that short, a whole 60-second cycle, a Q that reaches or exceeds the cycle length, and a change of settings in the middle of a cycle all fit in a few hundred clocks. An irregular enable pattern, together with clear strobes, exercises the hold behaviour and the case where a set and a clear meet in the same cycle.

// File: rtl/rtc_dc_pkg.sv
// Shared types and helpers for the drift-compensated time base.
// Assumes the cycle length never exceeds 60, so a 6-bit second index suffices.
package rtc_dc_pkg;

    localparam int IDX_W = 6;

    typedef enum logic [1:0] {
        CYC_5  = 2'd0,
        CYC_15 = 2'd1,
        CYC_30 = 2'd2,
        CYC_60 = 2'd3
    } cyc_sel_e;

    // Map a cycle select code to its length in seconds.
    function automatic logic [IDX_W-1:0] cyc_len(input cyc_sel_e s);
        case (s)
            CYC_5:   cyc_len = IDX_W'(5);
            CYC_15:  cyc_len = IDX_W'(15);
            CYC_30:  cyc_len = IDX_W'(30);
            default: cyc_len = IDX_W'(60);
        endcase
    endfunction

endpackage

// File: rtl/rtc_dc_cycle.sv
// Compensation cycle controller.
// Holds shadow copies of M, cycle length, Q and the compensation enable. The
// copies are loaded on the first clock after reset and at every cycle boundary.
// Tracks the second index inside the cycle and supplies the match value for the
// current second.
// Assumes M + 1 fits in CW+1 bits; the counter compares against that width.
module rtc_dc_cycle
    import rtc_dc_pkg::*;
#(
    parameter int CW = 16,
    parameter int QW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_end,
    input  logic [CW-1:0] mod_val,
    input  logic [1:0]    cyc_sel,
    input  logic [QW-1:0] stretch_q,
    input  logic          comp_en,
    output logic          run,
    output logic [CW:0]   match_val,
    output logic          last_pulse
);

    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    logic             pend;
    logic [CW-1:0]    m_act;
    logic [IDX_W-1:0] len_act;
    logic [QW-1:0]    q_act;
    logic             en_act;
    logic [IDX_W-1:0] idx;
    logic             stretch;
    logic             at_end;

    // Stretch the current second while its index is still below Q.
    always_comb begin
        stretch   = en_act && (int'(idx) < int'(q_act));
        match_val = {1'b0, m_act} + {{CW{1'b0}}, stretch};
        at_end    = (idx == len_act - IDX_ONE);
    end

    assign run = !pend;

    // Second index, shadow reloads and the last-second pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend       <= 1'b1;
            m_act      <= '0;
            len_act    <= cyc_len(CYC_5);
            q_act      <= '0;
            en_act     <= 1'b0;
            idx        <= '0;
            last_pulse <= 1'b0;
        end else begin
            last_pulse <= 1'b0;
            if (pend) begin
                pend    <= 1'b0;
                m_act   <= mod_val;
                len_act <= cyc_len(cyc_sel_e'(cyc_sel));
                q_act   <= stretch_q;
                en_act  <= comp_en;
            end else if (sec_end) begin
                if (at_end) begin
                    idx     <= '0;
                    m_act   <= mod_val;
                    len_act <= cyc_len(cyc_sel_e'(cyc_sel));
                    q_act   <= stretch_q;
                    en_act  <= comp_en;
                end else begin
                    idx <= idx + IDX_ONE;
                    if (en_act && (idx + IDX_ONE == len_act - IDX_ONE))
                        last_pulse <= 1'b1;
                end
            end
        end
    end

    // R3: the second index stays inside the active cycle
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |-> idx < len_act);

    // R5: with no stretch configured the match value equals M
    p_no_stretch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_act || q_act == '0) |-> match_val == {1'b0, m_act});

    // R7: the shadow settings change only at a reload point
    p_cfg_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(pend) && !$past(sec_end)
            |-> $stable(m_act) && $stable(q_act) && $stable(len_act));

    // R9: the last-second pulse only appears at index L-1 with compensation on
    p_last_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        last_pulse |-> (idx == len_act - IDX_ONE) && en_act);

endmodule

// File: rtl/rtc_dc_count.sv
// Free-running counter with modulo match.
// Advances on each step and wraps to 0 on the step that finds the count equal to
// the match value. Emits a one-cycle second tick on the wrap and a quarter tick
// when the new count lands on 0, X/4, X/2 or 3X/4 (rounded down).
// Assumes match_val stays constant within a second.
module rtc_dc_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [CW:0]   match_val,
    output logic [CW-1:0] count,
    output logic          sec_end,
    output logic          sec_tick,
    output logic          qtr_tick
);

    localparam int       XW  = CW + 3;
    localparam logic [XW-1:0] ONE = XW'(1);

    logic [XW-1:0] x_ext;
    logic [XW-1:0] nxt;
    logic [XW-1:0] pt_q1;
    logic [XW-1:0] pt_q2;
    logic [XW-1:0] pt_q3;
    logic          pt_hit;

    // Quarter points of the active match value and the hit test on the next count.
    always_comb begin
        x_ext  = {2'b00, match_val};
        nxt    = {3'b000, count} + ONE;
        pt_q1  = x_ext >> 2;
        pt_q2  = x_ext >> 1;
        pt_q3  = ((x_ext << 1) + x_ext) >> 2;
        pt_hit = (nxt == pt_q1) || (nxt == pt_q2) || (nxt == pt_q3);
    end

    assign sec_end = step && ({1'b0, count} == match_val);

    // Count, wrap and tick generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            sec_tick <= 1'b0;
            qtr_tick <= 1'b0;
        end else begin
            sec_tick <= 1'b0;
            qtr_tick <= 1'b0;
            if (step) begin
                if (sec_end) begin
                    count    <= '0;
                    sec_tick <= 1'b1;
                    qtr_tick <= 1'b1;
                end else begin
                    count    <= count + 1'b1;
                    qtr_tick <= pt_hit;
                end
            end
        end
    end

    // R1: a step that is not a wrap adds exactly one
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(step) && !$past(sec_end)
            |-> count == $past(count) + 1'b1);

    // R1: the count holds without a step
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(step) |-> $stable(count));

    // R2: a second tick coincides with a zero count
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> count == '0);

    // R8: the wrap is also a quarter point
    p_wrap_qtr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> qtr_tick);

endmodule

// File: rtl/rtc_dc_flag.sv
// Sticky status flag with clear strobe and interrupt gate.
// A set wins over a clear arriving in the same cycle.
module rtc_dc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic ie_i,
    output logic flag_o,
    output logic irq_o
);

    // Hold the flag until a clear strobe arrives without a concurrent set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    assign irq_o = flag_o && ie_i;

    // R11: a set always lands, even with a clear pending
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(set_i) |-> flag_o);

    // R11: a lone clear empties the flag
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(clr_i) && !$past(set_i) |-> !flag_o);

endmodule

// File: rtl/rtc_drift_comp.sv
// Drift-compensated one-second time base: top level.
// Joins the cycle controller, the match counter and two sticky flags.
// Assumes mod_val is at least 3 and below the counter's full scale.
module rtc_drift_comp #(
    parameter int CNT_W = 16,
    parameter int Q_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] mod_val,
    input  logic [1:0]       cyc_sel,
    input  logic [Q_W-1:0]   stretch_q,
    input  logic             comp_en,
    input  logic             tick_ie,
    input  logic             comp_ie,
    input  logic             tick_clr,
    input  logic             comp_clr,
    output logic [CNT_W-1:0] count,
    output logic             sec_tick,
    output logic             qtr_tick,
    output logic             tick_flag,
    output logic             comp_flag,
    output logic             tick_irq,
    output logic             comp_irq
);

    localparam int N_FLAG = 2;

    logic             run;
    logic             sec_end;
    logic             last_pulse;
    logic [CNT_W:0]   match_val;
    logic [N_FLAG-1:0] f_set, f_clr, f_ie, f_flag, f_irq;

    rtc_dc_cycle #(.CW(CNT_W), .QW(Q_W)) u_cycle (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_end    (sec_end),
        .mod_val    (mod_val),
        .cyc_sel    (cyc_sel),
        .stretch_q  (stretch_q),
        .comp_en    (comp_en),
        .run        (run),
        .match_val  (match_val),
        .last_pulse (last_pulse)
    );

    rtc_dc_count #(.CW(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (cnt_en && run),
        .match_val (match_val),
        .count     (count),
        .sec_end   (sec_end),
        .sec_tick  (sec_tick),
        .qtr_tick  (qtr_tick)
    );

    // Flag 0 records quarter ticks, flag 1 the last second of a cycle.
    assign f_set = {last_pulse, qtr_tick};
    assign f_clr = {comp_clr, tick_clr};
    assign f_ie  = {comp_ie, tick_ie};

    for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
        rtc_dc_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (f_set[g]),
            .clr_i  (f_clr[g]),
            .ie_i   (f_ie[g]),
            .flag_o (f_flag[g]),
            .irq_o  (f_irq[g])
        );
    end

    assign tick_flag = f_flag[0];
    assign comp_flag = f_flag[1];
    assign tick_irq  = f_irq[0];
    assign comp_irq  = f_irq[1];

endmodule

// File: tb/tb_rtc_drift_comp.sv
`timescale 1ns/1ps
module tb_rtc_drift_comp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [15:0] mod_val = 16'd6;
    logic [1:0]  cyc_sel = 2'd0;
    logic [5:0]  stretch_q = 6'd0;
    logic        comp_en = 1'b0;
    logic        tick_ie = 1'b0, comp_ie = 1'b0, tick_clr = 1'b0, comp_clr = 1'b0;
    logic [15:0] count;
    logic        sec_tick, qtr_tick, tick_flag, comp_flag, tick_irq, comp_irq;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    int tick_t[$];

    // reference model state
    int m_cnt = 0, m_idx = 0, m_M = 0, m_L = 5, m_Q = 0;
    bit m_on = 0, m_pend = 1, m_sec = 0, m_qtr = 0, m_last = 0, m_tf = 0, m_cf = 0;

    always #2.5 clk = ~clk;

    rtc_drift_comp dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mod_val(mod_val),
        .cyc_sel(cyc_sel), .stretch_q(stretch_q), .comp_en(comp_en),
        .tick_ie(tick_ie), .comp_ie(comp_ie), .tick_clr(tick_clr), .comp_clr(comp_clr),
        .count(count), .sec_tick(sec_tick), .qtr_tick(qtr_tick),
        .tick_flag(tick_flag), .comp_flag(comp_flag), .tick_irq(tick_irq), .comp_irq(comp_irq)
    );

    function automatic int len_of(input int s);
        case (s)
            0: return 5;
            1: return 15;
            2: return 30;
            default: return 60;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        bit n_sec, n_qtr, n_last, ld;
        int x;
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_idx = 0; m_pend = 1; m_sec = 0; m_qtr = 0;
            m_last = 0; m_tf = 0; m_cf = 0;
        end else begin
            if (m_qtr) m_tf = 1; else if (tick_clr) m_tf = 0;
            if (m_last) m_cf = 1; else if (comp_clr) m_cf = 0;
            n_sec = 0; n_qtr = 0; n_last = 0; ld = 0;
            if (m_pend) begin
                ld = 1; m_pend = 0;
            end else if (cnt_en) begin
                x = m_M + ((m_on && m_idx < m_Q) ? 1 : 0);
                if (m_cnt == x) begin
                    m_cnt = 0; n_sec = 1; n_qtr = 1;
                    if (m_idx == m_L - 1) begin
                        m_idx = 0; ld = 1;
                    end else begin
                        m_idx++;
                        if (m_on && m_idx == m_L - 1) n_last = 1;
                    end
                end else begin
                    m_cnt++;
                    if (m_cnt == x / 4 || m_cnt == x / 2 || m_cnt == (3 * x) / 4) n_qtr = 1;
                end
            end
            if (ld) begin
                m_M = int'(mod_val); m_L = len_of(int'(cyc_sel));
                m_Q = int'(stretch_q); m_on = comp_en;
            end
            m_sec = n_sec; m_qtr = n_qtr; m_last = n_last;
        end
    end

    // per-cycle comparison and tick timestamping, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk(int'(count) == m_cnt, "R1 count", int'(count), m_cnt);
            chk(sec_tick == m_sec, "R2 sec_tick", int'(sec_tick), int'(m_sec));
            chk(qtr_tick == m_qtr, "R8 qtr_tick", int'(qtr_tick), int'(m_qtr));
            chk(tick_flag == m_tf, "R10 tick_flag", int'(tick_flag), int'(m_tf));
            chk(comp_flag == m_cf, "R9 comp_flag", int'(comp_flag), int'(m_cf));
            chk(tick_irq == (m_tf && tick_ie), "R12 tick_irq", int'(tick_irq), int'(m_tf && tick_ie));
            chk(comp_irq == (m_cf && comp_ie), "R12 comp_irq", int'(comp_irq), int'(m_cf && comp_ie));
            if (sec_tick) tick_t.push_back(cyc);
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic start(input int m, input int sel, input int q, input bit on);
        @(negedge clk);
        rst_n = 0; cnt_en = 0; tick_clr = 0; comp_clr = 0;
        mod_val = 16'(m); cyc_sel = 2'(sel); stretch_q = 6'(q); comp_en = on;
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(count == 16'd0 && !sec_tick && !qtr_tick && !tick_flag && !comp_flag,
            "R13 reset state", int'(count), 0);
        rst_n = 1; cnt_en = 1;
        tick_t.delete();
    endtask

    task automatic wait_ticks(input int n);
        while (tick_t.size() < n) @(negedge clk);
    endtask

    // period between tick n and n+1 belongs to second index (n+1) mod L
    task automatic check_periods(input int first, input int last, input int m,
                                 input int l, input int q, input bit on, input string tag);
        for (int n = first; n <= last; n++) begin
            int idx = (n + 1) % l;
            int exp = m + 1 + ((on && idx < q) ? 1 : 0);
            chk(tick_t[n + 1] - tick_t[n] == exp, tag, tick_t[n + 1] - tick_t[n], exp);
        end
    endtask

    initial begin
        int lfsr;
        tick_ie = 1; comp_ie = 1;
        // R4 and R3: five-second cycle, two stretched seconds
        start(6, 0, 2, 1);
        wait_ticks(12);
        check_periods(0, 10, 6, 5, 2, 1, "R4 stretch pattern");
        // R5: Q of zero
        start(9, 1, 0, 1);
        wait_ticks(18);
        check_periods(0, 16, 9, 15, 0, 1, "R5 q zero");
        // R5: compensation off
        start(5, 0, 3, 0);
        wait_ticks(8);
        check_periods(0, 6, 5, 5, 0, 0, "R5 comp off");
        // R6: Q above the cycle length
        start(5, 0, 7, 1);
        wait_ticks(12);
        check_periods(0, 10, 5, 5, 5, 1, "R6 q over length");
        // R3: sixty-second cycle
        start(4, 3, 20, 1);
        wait_ticks(125);
        check_periods(0, 123, 4, 60, 20, 1, "R3 sixty second cycle");
        // R7: mid-cycle change takes effect at the next cycle
        start(6, 0, 1, 1);
        wait_ticks(2);
        mod_val = 16'd10; stretch_q = 6'd4;
        wait_ticks(10);
        check_periods(1, 3, 6, 5, 1, 1, "R7 old settings kept");
        check_periods(4, 8, 10, 5, 4, 1, "R7 new settings applied");
        // R11: lone clear empties tick flag
        while (!(tick_flag && !qtr_tick)) @(negedge clk);
        tick_clr = 1; @(negedge clk); tick_clr = 0;
        chk(!tick_flag, "R11 clear", int'(tick_flag), 0);
        // R11: set wins when clear coincides with a quarter tick
        while (!qtr_tick) @(negedge clk);
        tick_clr = 1; @(negedge clk); tick_clr = 0;
        chk(tick_flag, "R11 set wins", int'(tick_flag), 1);
        // R9: cycle flag clears on strobe
        while (!comp_flag) @(negedge clk);
        comp_clr = 1; @(negedge clk); comp_clr = 0;
        chk(!comp_flag || m_cf, "R9 comp clear", int'(comp_flag), int'(m_cf));
        // R1 and R12: irregular enable, gated interrupts and stray clears, thirty-second cycle
        start(7, 2, 11, 1);
        lfsr = 32'h1ace;
        for (int i = 0; i < 1500; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
            cnt_en = lfsr[0] | lfsr[3];
            tick_clr = (lfsr[7:4] == 4'h3);
            comp_clr = (lfsr[11:8] == 4'h5);
            tick_ie = lfsr[9];
            comp_ie = lfsr[2];
            @(negedge clk);
        end
        tick_clr = 0; comp_clr = 0;
        @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule